// File: doc/BRIEF.md
# Flash Command Interface Controller

This controller sits between a processor write/read bus and a small on-chip nonvolatile array model. Bus writes are decoded as commands. Byte program and block erase each take a setup write followed by a second write, and an internal write sequencer then carries the operation out over a configurable number of clock cycles. Reads return either an array byte or a status byte, depending on the current read mode. While the sequencer is busy, reads always return the status byte.

The array is split into five erase blocks of unequal size, in the ratio 16:12:1:1:2 allocation units from address zero upward: a large main block, a smaller main block, two parameter blocks, and a boot block at the top of the map. A hardware input guards the boot block. When it is low, program and erase aimed at the boot block change nothing. The attempt is recorded only as a sticky flag in the status byte.

Erase time depends on the class of the block. A parameter or boot block takes `ERASE_SHORT` cycles. A main block takes `ceil(2.4 * ERASE_SHORT)` cycles. A program takes `PROG_CYCLES` cycles.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset, reads return array data. The status byte is 80h, and every array byte reads FFh.
- R2: Writing FFh selects array reads, and writing 70h selects status reads. The status byte has bit 7 set when the block is ready, bit 5 for an erase error, bit 4 for a program error and bit 3 for a lock violation. All other bits read 0.
- R3: Writing 40h and then a data byte D to address A makes byte A become (old AND D) once the operation ends. Other bytes do not change, and reads switch to status.
- R4: A program whose data has a 1 in a bit position where the old byte holds 0 sets status bit 4.
- R5: Writing 20h and then D0h to any address of a block sets every byte of that block to FFh.
- R6: With the default allocation unit of 4 bytes, the block map is as follows. Addresses 0-63 are main block A, 64-111 are main block B, 112-115 are parameter block A, 116-119 are parameter block B, and 120-127 are the boot block. An erase touches only its own block.
- R7: If the second write after 20h is anything other than D0h, no erase takes place and status bit 5 is set.
- R8: While `boot_unlock` is low, program and erase aimed at the boot block leave the array unchanged. They set status bit 3 and keep the ready bit at 1.
- R9: The ready bit reads 0 for exactly `PROG_CYCLES` samples after a program data write. After an erase confirm it reads 0 for `ERASE_SHORT` samples on a parameter or boot block, and for `ceil(2.4*ERASE_SHORT)` samples on a main block (5 and 12 with the defaults).
- R10: While busy, reads return the status byte whatever the read mode, and every bus write is ignored.
- R11: Status bits 5, 4 and 3 stay set until a 50h write clears them. A 50h write does not change the read mode.
- R12: In the idle state, a write of any byte that is not a command code changes neither the read mode nor the status byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe; one write per cycle in which it is high |
| bus_addr | input | UNIT_LG+5 | Byte address for reads and writes |
| bus_wdata | input | 8 | Command or program data byte |
| bus_rdata | output | 8 | Array byte or status byte, combinational from the address |
| boot_unlock | input | 1 | High permits program and erase of the boot block |

## Verification
A wrong sequencer count shows up on the ready bit of the status byte. That bit falls one sample early or late, within the program or erase window. A wrong block decode or a wrong lock check shows up as an array byte that reads FFh where the previous value should remain, or the reverse. This appears on the first array read after the operation. A lost command state shows up as a wrong read mode or a missing error bit on the very next read.

// File: rtl/flash_cif_pkg.sv
package flash_cif_pkg;

    localparam int UNIT_COUNT = 32;
    localparam int UNIT_W     = 5;

    localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
    localparam logic [7:0] CMD_READ_STATUS = 8'h70;
    localparam logic [7:0] CMD_CLEAR_STAT  = 8'h50;
    localparam logic [7:0] CMD_PROG_SETUP  = 8'h40;
    localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
    localparam logic [7:0] CMD_ERASE_CONF  = 8'hD0;

    typedef enum logic [2:0] {
        BLK_MAIN_A = 3'd0,
        BLK_MAIN_B = 3'd1,
        BLK_PAR_A  = 3'd2,
        BLK_PAR_B  = 3'd3,
        BLK_BOOT   = 3'd4
    } blk_e;

    // unit ratio 16:12:1:1:2, boot block at the top of the map
    function automatic blk_e unit_blk(input logic [UNIT_W-1:0] u);
        if (u < 5'd16)       return BLK_MAIN_A;
        else if (u < 5'd28)  return BLK_MAIN_B;
        else if (u == 5'd28) return BLK_PAR_A;
        else if (u == 5'd29) return BLK_PAR_B;
        else                 return BLK_BOOT;
    endfunction

endpackage

// File: rtl/flash_blk_decode.sv
module flash_blk_decode
    import flash_cif_pkg::*;
#(
    parameter int UNIT_LG = 2
) (
    input  logic [UNIT_LG+UNIT_W-1:0] addr,
    output blk_e                      blk,
    output logic                      is_boot,
    output logic                      is_main
);
    always_comb begin
        blk     = unit_blk(addr[UNIT_LG+UNIT_W-1:UNIT_LG]);
        is_boot = (blk == BLK_BOOT);
        is_main = (blk == BLK_MAIN_A) || (blk == BLK_MAIN_B);
    end
endmodule

// File: rtl/flash_array.sv
module flash_array
    import flash_cif_pkg::*;
#(
    parameter int UNIT_LG = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [UNIT_LG+UNIT_W-1:0] rd_addr,
    output logic [7:0]         rd_data,
    input  logic [UNIT_LG+UNIT_W-1:0] chk_addr,
    output logic [7:0]         chk_data,
    input  logic               prog_en,
    input  logic [7:0]         prog_data,
    input  logic               erase_en,
    input  blk_e               erase_blk
);
    localparam int AW    = UNIT_LG + UNIT_W;
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem_q [DEPTH];
    logic [7:0] mem_d [DEPTH];

    assign rd_data  = mem_q[rd_addr];
    assign chk_data = mem_q[chk_addr];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
            if (erase_en && (unit_blk(UNIT_W'(i >> UNIT_LG)) == erase_blk)) begin
                mem_d[i] = 8'hFF;
            end
        end
        if (prog_en) begin
            mem_d[chk_addr] = mem_q[chk_addr] & prog_data;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) mem_q[i] <= 8'hFF;
            else        mem_q[i] <= mem_d[i];
        end
    end
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_cif_pkg::*;
#(
    parameter int UNIT_LG     = 2,
    parameter int PROG_CYCLES = 3,
    parameter int ERASE_SHORT = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [UNIT_LG+UNIT_W-1:0] bus_addr,
    input  logic [7:0]         bus_wdata,
    input  blk_e               addr_blk,
    input  logic               addr_boot,
    input  logic               addr_main,
    input  logic               boot_unlock,
    input  logic [7:0]         old_byte,
    output logic               busy,
    output logic               rd_stat,
    output logic [7:0]         status,
    output logic               prog_en,
    output logic [UNIT_LG+UNIT_W-1:0] prog_addr,
    output logic [7:0]         prog_data,
    output logic               erase_en,
    output blk_e               erase_blk
);
    localparam int AW         = UNIT_LG + UNIT_W;
    localparam int ERASE_LONG = (ERASE_SHORT * 12 + 4) / 5;
    localparam int CNT_W      = $clog2(ERASE_LONG + 1);

    typedef enum logic [1:0] {ST_IDLE, ST_PSET, ST_ESET, ST_BUSY} st_e;

    typedef struct packed {
        st_e             st;
        logic            rd_stat;
        logic            err_e;
        logic            err_p;
        logic            err_l;
        logic            is_erase;
        logic [CNT_W-1:0] cnt;
        logic [AW-1:0]   addr;
        logic [7:0]      data;
        blk_e            blk;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d    = ctl_q;
        prog_en  = 1'b0;
        erase_en = 1'b0;
        case (ctl_q.st)
            ST_BUSY: begin
                if (ctl_q.cnt == CNT_W'(1)) begin
                    ctl_d.st = ST_IDLE;
                    if (ctl_q.is_erase) begin
                        erase_en = 1'b1;
                    end else begin
                        prog_en = 1'b1;
                        if ((old_byte & ctl_q.data) != ctl_q.data) ctl_d.err_p = 1'b1;
                    end
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            ST_PSET: begin
                if (bus_we) begin
                    ctl_d.rd_stat = 1'b1;
                    ctl_d.st      = ST_IDLE;
                    if (addr_boot && !boot_unlock) begin
                        ctl_d.err_l = 1'b1;
                    end else begin
                        ctl_d.st       = ST_BUSY;
                        ctl_d.is_erase = 1'b0;
                        ctl_d.cnt      = CNT_W'(PROG_CYCLES);
                        ctl_d.addr     = bus_addr;
                        ctl_d.data     = bus_wdata;
                    end
                end
            end
            ST_ESET: begin
                if (bus_we) begin
                    ctl_d.rd_stat = 1'b1;
                    ctl_d.st      = ST_IDLE;
                    if (bus_wdata != CMD_ERASE_CONF) begin
                        ctl_d.err_e = 1'b1;
                    end else if (addr_boot && !boot_unlock) begin
                        ctl_d.err_l = 1'b1;
                    end else begin
                        ctl_d.st       = ST_BUSY;
                        ctl_d.is_erase = 1'b1;
                        ctl_d.cnt      = addr_main ? CNT_W'(ERASE_LONG) : CNT_W'(ERASE_SHORT);
                        ctl_d.blk      = addr_blk;
                    end
                end
            end
            default: begin
                if (bus_we) begin
                    case (bus_wdata)
                        CMD_READ_ARRAY:  ctl_d.rd_stat = 1'b0;
                        CMD_READ_STATUS: ctl_d.rd_stat = 1'b1;
                        CMD_CLEAR_STAT: begin
                            ctl_d.err_e = 1'b0;
                            ctl_d.err_p = 1'b0;
                            ctl_d.err_l = 1'b0;
                        end
                        CMD_PROG_SETUP: begin
                            ctl_d.st      = ST_PSET;
                            ctl_d.rd_stat = 1'b1;
                        end
                        CMD_ERASE_SETUP: begin
                            ctl_d.st      = ST_ESET;
                            ctl_d.rd_stat = 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q          <= '0;
            ctl_q.st       <= ST_IDLE;
            ctl_q.blk      <= BLK_MAIN_A;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy      = (ctl_q.st == ST_BUSY);
    assign rd_stat   = ctl_q.rd_stat;
    assign status    = {~busy, 1'b0, ctl_q.err_e, ctl_q.err_p, ctl_q.err_l, 3'b000};
    assign prog_addr = ctl_q.addr;
    assign prog_data = ctl_q.data;
    assign erase_blk = ctl_q.blk;
endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
    import flash_cif_pkg::*;
#(
    parameter int UNIT_LG     = 2,
    parameter int PROG_CYCLES = 3,
    parameter int ERASE_SHORT = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_we,
    input  logic [UNIT_LG+UNIT_W-1:0] bus_addr,
    input  logic [7:0]                bus_wdata,
    output logic [7:0]                bus_rdata,
    input  logic                      boot_unlock
);
    localparam int AW = UNIT_LG + UNIT_W;

    blk_e          addr_blk;
    logic          addr_boot;
    logic          addr_main;
    logic          ctl_busy;
    logic          ctl_rd_stat;
    logic [7:0]    ctl_status;
    logic          prog_en;
    logic [AW-1:0] prog_addr;
    logic [7:0]    prog_data;
    logic          erase_en;
    blk_e          erase_blk;
    logic [7:0]    arr_byte;
    logic [7:0]    old_byte;

    flash_blk_decode #(.UNIT_LG(UNIT_LG)) u_dec (
        .addr    (bus_addr),
        .blk     (addr_blk),
        .is_boot (addr_boot),
        .is_main (addr_main)
    );

    flash_cmd_fsm #(
        .UNIT_LG     (UNIT_LG),
        .PROG_CYCLES (PROG_CYCLES),
        .ERASE_SHORT (ERASE_SHORT)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .addr_blk    (addr_blk),
        .addr_boot   (addr_boot),
        .addr_main   (addr_main),
        .boot_unlock (boot_unlock),
        .old_byte    (old_byte),
        .busy        (ctl_busy),
        .rd_stat     (ctl_rd_stat),
        .status      (ctl_status),
        .prog_en     (prog_en),
        .prog_addr   (prog_addr),
        .prog_data   (prog_data),
        .erase_en    (erase_en),
        .erase_blk   (erase_blk)
    );

    flash_array #(.UNIT_LG(UNIT_LG)) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr   (bus_addr),
        .rd_data   (arr_byte),
        .chk_addr  (prog_addr),
        .chk_data  (old_byte),
        .prog_en   (prog_en),
        .prog_data (prog_data),
        .erase_en  (erase_en),
        .erase_blk (erase_blk)
    );

    assign bus_rdata = (ctl_busy || ctl_rd_stat) ? ctl_status : arr_byte;
endmodule

// File: rtl/flash_cmd_if_chk.sv
module flash_cmd_if_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_we,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       boot_unlock,
    input logic       addr_boot,
    input logic       ctl_busy,
    input logic [7:0] ctl_status,
    input logic       prog_en,
    input logic       erase_en
);
    AST_BUSY_READS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_busy |-> (bus_rdata[7] == 1'b0)); // R10

    AST_LOCKED_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_busy) |-> !($past(addr_boot) && !$past(boot_unlock))); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ctl_status[5]) || $fell(ctl_status[4]) || $fell(ctl_status[3]))
        |-> ($past(bus_we) && ($past(bus_wdata) == 8'h50))); // R11

    AST_COMMIT_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en || erase_en) |=> !ctl_busy); // R9

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_busy && !prog_en && !erase_en) |=> ctl_busy); // R10

    AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_en && erase_en)); // R3
endmodule

bind flash_cmd_if flash_cmd_if_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .boot_unlock (boot_unlock),
    .addr_boot   (addr_boot),
    .ctl_busy    (ctl_busy),
    .ctl_status  (ctl_status),
    .prog_en     (prog_en),
    .erase_en    (erase_en)
);

// File: tb/flash_cmd_if_tb.sv
module flash_cmd_if_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bus_we;
    logic [6:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       boot_unlock;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    flash_cmd_if u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .boot_unlock (boot_unlock)
    );

    typedef struct packed {
        logic       we;
        logic [6:0] a;
        logic [7:0] d;
        logic [7:0] e;
        logic [3:0] r;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 7'd5, 8'h00, 8'hFF, 4'd1},  // R1 array reads erased
        '{1'b1, 7'd5, 8'h70, 8'h80, 4'd2},  // R2 status mode
        '{1'b1, 7'd5, 8'hFF, 8'hFF, 4'd2},  // R2 array mode
        '{1'b1, 7'd5, 8'h40, 8'h80, 4'd3},  // R3 setup -> status
        '{1'b1, 7'd5, 8'hA5, 8'h00, 4'd9},  // R9 busy 1
        '{1'b0, 7'd5, 8'h00, 8'h00, 4'd9},  // R9 busy 2
        '{1'b0, 7'd5, 8'h00, 8'h00, 4'd9},  // R9 busy 3
        '{1'b0, 7'd5, 8'h00, 8'h80, 4'd9},  // R9 ready
        '{1'b1, 7'd5, 8'hFF, 8'hA5, 4'd3},  // R3 programmed byte
        '{1'b0, 7'd4, 8'h00, 8'hFF, 4'd3},  // R3 neighbour untouched
        '{1'b1, 7'd5, 8'h40, 8'h80, 4'd3},
        '{1'b1, 7'd5, 8'h0F, 8'h00, 4'd9},
        '{1'b0, 7'd5, 8'h00, 8'h00, 4'd9},
        '{1'b0, 7'd5, 8'h00, 8'h00, 4'd9},
        '{1'b0, 7'd5, 8'h00, 8'h90, 4'd4},  // R4 raise-bit error
        '{1'b1, 7'd5, 8'hFF, 8'h05, 4'd3},  // R3 AND result
        '{1'b1, 7'd5, 8'h50, 8'h05, 4'd11}, // R11 mode kept
        '{1'b1, 7'd5, 8'h70, 8'h80, 4'd11}, // R11 bits cleared
        '{1'b1, 7'd5, 8'h20, 8'h80, 4'd7},
        '{1'b1, 7'd5, 8'h33, 8'hA0, 4'd7},  // R7 bad confirm
        '{1'b1, 7'd5, 8'h70, 8'hA0, 4'd11}, // R11 sticky
        '{1'b1, 7'd5, 8'hFF, 8'h05, 4'd7},  // R7 nothing erased
        '{1'b1, 7'd5, 8'h50, 8'h05, 4'd11},
        '{1'b1, 7'd5, 8'h99, 8'h05, 4'd12}, // R12 unknown ignored
        '{1'b1, 7'd5, 8'h70, 8'h80, 4'd12}
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic step(input logic we, input logic [6:0] a, input logic [7:0] d);
        bus_we    = we;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic busy_len(output int n);
        logic [7:0] v;
        n = 0;
        rd(bus_addr, v);
        while (v[7] == 1'b0 && n < 100) begin
            n++;
            step(1'b0, bus_addr, 8'h00);
            rd(bus_addr, v);
        end
    endtask

    task automatic prog(input logic [6:0] a, input logic [7:0] d, output int n);
        step(1'b1, a, 8'h40);
        step(1'b1, a, d);
        busy_len(n);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        #(200000 * 10);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] v;
        int n;
        rst_n       = 1'b0;
        bus_we      = 1'b0;
        bus_addr    = '0;
        bus_wdata   = '0;
        boot_unlock = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 status after reset
        step(1'b1, 7'd0, 8'h70);
        rd(7'd0, v); check("R1 reset status", v, 8'h80);
        step(1'b1, 7'd0, 8'hFF);

        for (int i = 0; i < NV; i++) begin
            bus_we    = VEC[i].we;
            bus_addr  = VEC[i].a;
            bus_wdata = VEC[i].d;
            @(posedge clk);
            @(negedge clk);
            check($sformatf("R%0d vec %0d", VEC[i].r, i), bus_rdata, VEC[i].e);
        end
        bus_we = 1'b0;

        // R5 R6 parameter block erase
        prog(7'd113, 8'h00, n);
        prog(7'd117, 8'h00, n);
        prog(7'd111, 8'h00, n);
        check("R9 program cycles", 8'(n), 8'd3);
        step(1'b1, 7'd114, 8'h20);
        step(1'b1, 7'd114, 8'hD0);
        busy_len(n); check("R9 param erase cycles", 8'(n), 8'd5);
        step(1'b1, 7'd0, 8'hFF);
        rd(7'd113, v); check("R5 param A erased", v, 8'hFF);
        rd(7'd117, v); check("R6 param B untouched", v, 8'h00);
        rd(7'd111, v); check("R6 main B untouched", v, 8'h00);
        rd(7'd5, v);   check("R6 main A untouched", v, 8'h05);

        // R8 boot lock
        boot_unlock = 1'b0;
        step(1'b1, 7'd120, 8'h40);
        step(1'b1, 7'd120, 8'h00);
        rd(7'd120, v); check("R8 locked program status", v, 8'h88);
        step(1'b1, 7'd0, 8'hFF);
        rd(7'd120, v); check("R8 locked program no change", v, 8'hFF);
        boot_unlock = 1'b1;
        step(1'b1, 7'd0, 8'h50);
        prog(7'd121, 8'h00, n);
        boot_unlock = 1'b0;
        step(1'b1, 7'd127, 8'h20);
        step(1'b1, 7'd127, 8'hD0);
        rd(7'd127, v); check("R8 locked erase status", v, 8'h88);
        step(1'b1, 7'd0, 8'hFF);
        rd(7'd121, v); check("R8 locked erase no change", v, 8'h00);
        step(1'b1, 7'd0, 8'h50);
        boot_unlock = 1'b1;
        step(1'b1, 7'd124, 8'h20);
        step(1'b1, 7'd124, 8'hD0);
        busy_len(n); check("R9 boot erase cycles", 8'(n), 8'd5);
        step(1'b1, 7'd0, 8'hFF);
        rd(7'd121, v); check("R5 boot erased", v, 8'hFF);

        // R9 main block erase time
        step(1'b1, 7'd80, 8'h20);
        step(1'b1, 7'd80, 8'hD0);
        busy_len(n); check("R9 main erase cycles", 8'(n), 8'd12);
        step(1'b1, 7'd0, 8'hFF);
        rd(7'd111, v); check("R5 main B erased", v, 8'hFF);
        rd(7'd5, v);   check("R6 main A kept", v, 8'h05);

        // R10 writes ignored while busy
        step(1'b1, 7'd0, 8'h20);
        step(1'b1, 7'd0, 8'hD0);
        step(1'b1, 7'd0, 8'hFF);
        rd(7'd5, v); check("R10 busy read gives status", v, 8'h00);
        step(1'b1, 7'd5, 8'h40);
        busy_len(n);
        rd(7'd5, v); check("R10 mode write ignored", v, 8'h80);
        step(1'b1, 7'd5, 8'h00);
        step(1'b1, 7'd5, 8'hFF);
        rd(7'd5, v); check("R10 setup write ignored", v, 8'hFF);

        // R1 reset during an operation
        step(1'b1, 7'd5, 8'h40);
        step(1'b1, 7'd5, 8'h00);
        rst_n = 1'b0;
        step(1'b0, 7'd5, 8'h00);
        rst_n = 1'b1;
        rd(7'd5, v); check("R1 reset array read", v, 8'hFF);
        step(1'b1, 7'd5, 8'h70);
        rd(7'd5, v); check("R1 reset ready status", v, 8'h80);

        summary();
        $finish;
    end
endmodule